// File: doc/BRIEF.md
# Fermat-Modulus Residue Reducer

This block takes an unsigned operand of up to 2N bits and returns its residue modulo 2^N+1. It does not divide and it does not subtract in a loop. Because 2^N is congruent to -1 for this modulus, the block splits the operand into a lower and an upper N-bit half and subtracts the upper half from the lower one. When that difference is negative, it adds the modulus back once. The residue lies between 0 and 2^N inclusive, so it is N+1 bits wide.

The block is meant to be the last stage of a modular multiplier, such as those found in block-cipher datapaths that multiply modulo 2^16+1. It has an input strobe and an output strobe. The parameter PIPE selects the timing. With PIPE=0 the result is combinational. With PIPE=1 one register stage sits at the output, and the strobe is delayed to match.

Top module: `fermat_reducer`

## Requirements
- R1: For every operand value X below 2^(2N), `residue` equals X mod (2^N+1).
- R2: `residue` never exceeds 2^N. It equals 2^N exactly when the lower half is one less than the upper half. For example, an upper half of 1 with a lower half of 0 gives 2^N.
- R3: The lower half is operand bits N-1..0 and the upper half is bits 2N-1..N. When the lower half is at least the upper half, `residue` equals lower minus upper.
- R4: When the lower half is smaller than the upper half, `residue` equals lower minus upper plus 2^N+1. For example, an upper half of all ones with a lower half of 0 gives 2.
- R5: With PIPE=0, `out_valid` follows `in_valid`, and `residue` reflects `operand`, in the same cycle with no clock edge in between.
- R6: With PIPE=1, `residue` and `out_valid` appear one rising clock edge after `operand` and `in_valid` are sampled.
- R7: With PIPE=1, a clock edge at which `in_valid` is low leaves `residue` unchanged, whatever `operand` carries.
- R8: With PIPE=1, `out_valid` is 0 after any rising edge at which `rst_n` is low (synchronous, active-low reset).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge (used when PIPE=1) |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| operand | input | 2N | Value to reduce |
| out_valid | output | 1 | Residue strobe |
| residue | output | N+1 | Operand mod (2^N+1), 0..2^N |

## Verification
The hardest case to reach is the single residue 2^N. It needs the extra top bit, and it arises only when the difference is exactly -1. Random 32-bit operands hit it with a chance of about one in 65536. The bench therefore reaches it directly, with an upper half of 1 and a lower half of 0, and with other pairs whose halves differ by one. An exhaustive sweep at N=4 also covers every such pair. The other extreme of the correction, where the upper half is all ones and the lower half is 0, is likewise driven explicitly.

// File: rtl/fermat_pkg.sv
// Package: shared helpers for the Fermat-modulus reducer.
// Assumes: n is small enough that 2^n+1 fits in 64 bits.
package fermat_pkg;

    // Width of a residue for half-width n (must hold the value 2^n).
    function automatic int res_width(input int n);
        return n + 1;
    endfunction

    // Output timing variants selectable by the PIPE parameter.
    typedef enum int {
        TIMING_COMB = 0,
        TIMING_REG  = 1
    } timing_e;

endpackage

// File: rtl/fermat_split.sv
// Module: fermat_split
// Splits a 2N-bit operand into its lower and upper N-bit halves.
// Assumes: the operand is unsigned; no state.
module fermat_split #(
    parameter int N = 16
) (
    input  logic [2*N-1:0] operand,
    output logic [N-1:0]   lower,
    output logic [N-1:0]   upper
);
    // Purpose: route the two halves.
    always_comb begin
        lower = operand[N-1:0];
        upper = operand[2*N-1:N];
    end
endmodule

// File: rtl/fermat_sub.sv
// Module: fermat_sub
// Forms lower - upper in (N+1)-bit two's complement and flags a negative result.
// Assumes: both inputs are unsigned N-bit values, so the difference fits N+1 bits.
module fermat_sub #(
    parameter int N = 16
) (
    input  logic [N-1:0] lower,
    input  logic [N-1:0] upper,
    output logic [N:0]   diff,
    output logic         neg
);
    // Purpose: subtract with one bit of headroom; the top bit is the sign.
    always_comb begin
        diff = {1'b0, lower} - {1'b0, upper};
        neg  = diff[N];
    end
endmodule

// File: rtl/fermat_correct.sv
// Module: fermat_correct
// Adds 2^N+1 once to a negative difference and passes a non-negative one through.
// Assumes: diff lies in -(2^N-1) .. 2^N-1, so one correction is enough.
module fermat_correct #(
    parameter int N = 16
) (
    input  logic [N:0] diff,
    input  logic       neg,
    output logic [N:0] res
);
    localparam logic [N:0] MODV = {1'b1, {(N-1){1'b0}}, 1'b1};

    // Purpose: conditional add of the modulus; the wrap at N+1 bits is intended.
    always_comb begin
        res = neg ? (diff + MODV) : diff;
    end
endmodule

// File: rtl/fermat_stage.sv
// Module: fermat_stage
// Output timing: a wire (PIPE=0) or one register stage (PIPE=1).
// Assumes: with PIPE=1 the data register loads only on a valid strobe,
// and only the strobe is reset.
module fermat_stage #(
    parameter int W    = 17,
    parameter int PIPE = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         d_valid,
    input  logic [W-1:0] d,
    output logic         q_valid,
    output logic [W-1:0] q
);
    import fermat_pkg::*;

    generate
        if (PIPE == int'(TIMING_REG)) begin : g_reg
            logic         v_r;
            logic [W-1:0] d_r;

            // Purpose: strobe register with synchronous active-low reset.
            always_ff @(posedge clk) begin
                if (!rst_n) v_r <= 1'b0;
                else        v_r <= d_valid;
            end

            // Purpose: data register, loads only on a valid strobe.
            always_ff @(posedge clk) begin
                if (d_valid) d_r <= d;
            end

            assign q_valid = v_r;
            assign q       = d_r;

            // R6: the output strobe follows the input strobe one edge later.
            assert_valid_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
                d_valid |=> q_valid);
            assert_idle_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
                !d_valid |=> !q_valid);
            // R7: no strobe, no change of the held residue.
            assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
                !d_valid |=> $stable(q));
            // R8: the strobe is clear right after reset.
            assert_reset_R8: assert property (@(posedge clk)
                !rst_n |=> !q_valid);
        end else begin : g_comb
            assign q_valid = d_valid;
            assign q       = d;
        end
    endgenerate
endmodule

// File: rtl/fermat_reducer.sv
// Module: fermat_reducer (top)
// Reduces a 2N-bit operand modulo 2^N+1 by subtracting the upper half from
// the lower half and adding the modulus back once if the result is negative.
// Assumes: N >= 2; PIPE is 0 (combinational) or 1 (one register stage).
module fermat_reducer #(
    parameter int N    = 16,
    parameter int PIPE = 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               in_valid,
    input  logic [2*N-1:0]                     operand,
    output logic                               out_valid,
    output logic [fermat_pkg::res_width(N)-1:0] residue
);
    localparam int RW = fermat_pkg::res_width(N);

    logic [N-1:0]  lower, upper;
    logic [N:0]    diff;
    logic          neg;
    logic [RW-1:0] corr;

    fermat_split   #(.N(N)) u_split (.operand(operand), .lower(lower), .upper(upper));
    fermat_sub     #(.N(N)) u_sub   (.lower(lower), .upper(upper), .diff(diff), .neg(neg));
    fermat_correct #(.N(N)) u_corr  (.diff(diff), .neg(neg), .res(corr));

    fermat_stage #(.W(RW), .PIPE(PIPE)) u_stage (
        .clk(clk), .rst_n(rst_n),
        .d_valid(in_valid), .d(corr),
        .q_valid(out_valid), .q(residue)
    );

    // Range and congruence reference for the corrected value.
    localparam logic [N+1:0] MOD_W = (N + 2)'(1) << N | (N + 2)'(1);
    logic [N+1:0] back_sum;
    assign back_sum = {2'b00, upper} + {1'b0, corr};

    // R2: the residue never exceeds 2^N.
    assert_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> corr <= RW'(MOD_W - 1));
    // R1: residue + upper is congruent to lower (equals lower or lower + modulus).
    assert_congruent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (back_sum == {2'b00, lower}) || (back_sum == {2'b00, lower} + MOD_W));
    // R3: with no borrow, the residue is not larger than the lower half.
    assert_no_corr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (lower >= upper)) |-> corr <= {1'b0, lower});
    // R4: with a borrow, the residue is at least 2.
    assert_corr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (lower < upper)) |-> corr >= RW'(2));
endmodule

// File: tb/test_fermat_reducer.sv
`timescale 1ns/1ps
module test_fermat_reducer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    // Main instance: N=16, one register stage.
    logic        v16 = 1'b0;
    logic [31:0] op16 = '0;
    logic        ov16;
    logic [16:0] res16;
    fermat_reducer #(.N(16), .PIPE(1)) i_fermat_reducer (
        .clk(clk), .rst_n(rst_n), .in_valid(v16), .operand(op16),
        .out_valid(ov16), .residue(res16));

    // Second instance: N=4, combinational.
    logic       v4 = 1'b0;
    logic [7:0] op4 = '0;
    logic       ov4;
    logic [4:0] res4;
    fermat_reducer #(.N(4), .PIPE(0)) i_fermat_reducer_n4 (
        .clk(clk), .rst_n(rst_n), .in_valid(v4), .operand(op4),
        .out_valid(ov4), .residue(res4));

    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive one N=16 operand, then check it at the next falling edge (R6).
    task automatic pipe16(input string tag, input logic [31:0] a);
        @(negedge clk);
        v16 = 1'b1; op16 = a;
        @(negedge clk);
        chk({tag, " valid"}, longint'(ov16), 1);
        chk(tag, longint'(res16), longint'(a) % 65537);
        v16 = 1'b0;
    endtask

    // R8: reset clears the strobe, even while in_valid is high.
    task automatic t_reset;
        rst_n = 1'b0; v16 = 1'b1; op16 = 32'h0001_0000;
        repeat (3) @(negedge clk);
        chk("R8 out_valid under reset", longint'(ov16), 0);
        v16 = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 out_valid after reset", longint'(ov16), 0);
    endtask

    // R1, R3, R4, R5: exhaustive sweep at N=4, with a same-cycle combinational check.
    task automatic t_exhaustive_n4;
        for (int a = 0; a < 256; a++) begin
            @(negedge clk);
            v4 = a[0]; op4 = 8'(a);
            #0.5;
            chk("R5 valid follows", longint'(ov4), longint'(a[0]));
            if (a[3:0] >= a[7:4])
                chk("R3 no correction", longint'(res4), longint'(a[3:0]) - longint'(a[7:4]));
            else
                chk("R4 corrected", longint'(res4), longint'(a[3:0]) - longint'(a[7:4]) + 17);
            chk("R1 n4 mod", longint'(res4), longint'(a % 17));
        end
        v4 = 1'b0;
    endtask

    // R2, R3, R4: boundary operands at N=16.
    task automatic t_boundaries;
        pipe16("R2 top residue 2^N", 32'h0001_0000);
        chk("R2 equals 65536", longint'(res16), 65536);
        pipe16("R2 halves differ by one", 32'h1235_1234);
        chk("R2 equals 65536 again", longint'(res16), 65536);
        pipe16("R3 zero", 32'h0000_0000);
        pipe16("R3 all ones gives 0", 32'hFFFF_FFFF);
        pipe16("R3 low max", 32'h0000_FFFF);
        chk("R3 equals 65535", longint'(res16), 65535);
        pipe16("R4 high max low zero", 32'hFFFF_0000);
        chk("R4 equals 2", longint'(res16), 2);
    endtask

    // R1: random operands at N=16, back to back.
    task automatic t_random16;
        logic [31:0] prev;
        @(negedge clk);
        prev = $urandom;
        v16 = 1'b1; op16 = prev;
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] nxt;
            nxt = $urandom;
            @(negedge clk);
            chk("R1 random valid", longint'(ov16), 1);
            chk("R1 random mod", longint'(res16), longint'(prev) % 65537);
            op16 = nxt; prev = nxt;
        end
        @(negedge clk);
        v16 = 1'b0;
    endtask

    // R6, R7: latency and hold while in_valid is low.
    task automatic t_latency_hold;
        @(negedge clk);
        v16 = 1'b1; op16 = 32'h0005_0003;
        #0.5;
        chk("R6 no output before edge", longint'(ov16), 0);
        @(negedge clk);
        chk("R6 one-edge latency", longint'(res16), 65535);
        v16 = 1'b0; op16 = 32'h0000_0007;
        @(negedge clk);
        chk("R6 valid drops", longint'(ov16), 0);
        chk("R7 residue held", longint'(res16), 65535);
        op16 = 32'hABCD_0001;
        @(negedge clk);
        chk("R7 residue still held", longint'(res16), 65535);
    endtask

    initial begin
        t_reset();
        t_exhaustive_n4();
        t_boundaries();
        t_latency_hold();
        t_random16();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule